// File: doc/BRIEF.md
# Free-Running 64-bit Timer with Four Alarm Comparators

This block keeps a 64-bit count of elapsed time, advancing by one on every clock edge where the tick-enable input is high. Software reaches it through a 32-bit word-addressed register port with single-cycle write and read strobes. The 64-bit value is written and read as two halves, and an ordering rule keeps each pair coherent. To set the time, software stages the low half and then writes the high half, which commits both halves together. To read the time, software reads a capturing low-half register, which freezes the matching high half for a following read.

Each alarm holds a 32-bit target. Writing the target arms the alarm. When the low 32 bits of the time match an armed target on a ticking edge, the alarm fires once and sets a raw interrupt bit. Every alarm output passes through an enable mask and can also be forced. A sticky lock bit freezes the time-setting registers until reset.

Register word addresses: 0 stage low half (W), 1 commit high half (W), 2 capturing low read (R), 3 captured high read (R), 4 and 5 live low and high (R), 6 lock in bit 0, 7 armed bits, 8 raw interrupts, 9 interrupt enable, 10 interrupt force, 11 masked status, 12+i target of alarm i. Bit i of registers 7 to 11 belongs to alarm i.

Top module: `alarm_timer`

## Requirements
- R1: After reset the time is 0, every register reads 0 and all interrupt outputs are low.
- R2: The time rises by exactly one on each clock edge with tick_en high, carrying from the low half into the high half, and holds otherwise.
- R3: A write to address 0 stages a low half without changing the time. A write to address 1 loads {wdata, staged low} into the time on that edge, which takes priority over a tick.
- R4: Address 2 returns the live low half. A read strobe on it captures the live high half at the same edge, and address 3 then returns that captured value until the next capture.
- R5: Writing address 12+i stores the target and sets armed bit i, seen at address 7. Address 12+i reads the target back.
- R6: An armed alarm whose target equals the time's low 32 bits on an edge with tick_en high fires on that edge. Its raw bit (address 8) sets and its armed bit clears together, and it does not fire again unless re-armed.
- R7: A write to address 7 clears every armed bit written as 0 and leaves bits written as 1 unchanged, so a cancelled alarm never fires.
- R8: Writing 1 to a bit of address 8 clears that raw bit, writing 0 leaves it, and a firing on the same edge wins over the clear.
- R9: irq[i] equals (raw[i] OR force[i]) AND enable[i], with enable at address 9 and force at address 10, and address 11 reads the same masked vector.
- R10: Writing 1 to bit 0 of address 6 sets a lock that no write can clear. While it is set, writes to addresses 0 and 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count enable, one time unit per high cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used for read side effects) |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 4 | Per-alarm interrupt outputs |

## Verification
A corrupt armed bit shows up either as an alarm that fires when it was never set up or cancelled, or as one that never fires. In both cases the irq pins diverge on the first ticking edge where the low half matches the target. A wrong time or captured-high value shows on the very next read of addresses 2 to 5. Because the alarm compare depends on the time, an error in the count also moves every later firing. A broken lock or staging register is seen on the first read after a blocked or partial time write.

// File: rtl/alarm_timer_pkg.sv
// Package: register word addresses and widths shared by the timer and its checker.
// Assumes a 4-bit word address space with alarm targets at the top.
package alarm_timer_pkg;
    localparam int unsigned REG_AW = 4;
    localparam logic [REG_AW-1:0] A_SET_LO = 4'd0;
    localparam logic [REG_AW-1:0] A_SET_HI = 4'd1;
    localparam logic [REG_AW-1:0] A_RD_LO  = 4'd2;
    localparam logic [REG_AW-1:0] A_RD_HI  = 4'd3;
    localparam logic [REG_AW-1:0] A_NOW_LO = 4'd4;
    localparam logic [REG_AW-1:0] A_NOW_HI = 4'd5;
    localparam logic [REG_AW-1:0] A_LOCK   = 4'd6;
    localparam logic [REG_AW-1:0] A_ARMED  = 4'd7;
    localparam logic [REG_AW-1:0] A_RAW    = 4'd8;
    localparam logic [REG_AW-1:0] A_EN     = 4'd9;
    localparam logic [REG_AW-1:0] A_FORCE  = 4'd10;
    localparam logic [REG_AW-1:0] A_STAT   = 4'd11;
    localparam logic [REG_AW-1:0] A_TGT0   = 4'd12;
endpackage

// File: rtl/at_timebase.sv
// Module: 64-bit time counter with staged write and captured high-half read.
// Assumes the caller has already gated stage_wr/commit_wr with the lock.
module at_timebase #(
    parameter int unsigned HW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic            stage_wr,
    input  logic            commit_wr,
    input  logic            cap_rd,
    input  logic [HW-1:0]   wdata,
    output logic [2*HW-1:0] time_q,
    output logic [HW-1:0]   stage_q,
    output logic [HW-1:0]   hi_cap_q
);
    // Time register: a commit overrides counting.
    always_ff @(posedge clk) begin
        if (!rst_n)         time_q <= '0;
        else if (commit_wr) time_q <= {wdata, stage_q};
        else if (tick_en)   time_q <= time_q + 1'b1;
    end

    // Staged low half, waiting for the high-half commit.
    always_ff @(posedge clk) begin
        if (!rst_n)        stage_q <= '0;
        else if (stage_wr) stage_q <= wdata;
    end

    // High half frozen when the low half is read.
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_cap_q <= '0;
        else if (cap_rd) hi_cap_q <= time_q[2*HW-1:HW];
    end
endmodule

// File: rtl/at_alarm.sv
// Module: one alarm comparator with target, armed and raw interrupt state.
// Assumes it compares against the low half of the time only.
module at_alarm #(
    parameter int unsigned HW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic [HW-1:0] time_lo,
    input  logic          tgt_wr,
    input  logic [HW-1:0] wdata,
    input  logic          arm_wr,
    input  logic          arm_keep,
    input  logic          raw_clr,
    output logic          armed_q,
    output logic          raw_q,
    output logic [HW-1:0] tgt_q
);
    logic fire;
    assign fire = armed_q && tick_en && (time_lo == tgt_q);

    // Target value store.
    always_ff @(posedge clk) begin
        if (!rst_n)      tgt_q <= '0;
        else if (tgt_wr) tgt_q <= wdata;
    end

    // Armed state: a target write arms, a firing disarms, a 0 written to the bit cancels.
    always_ff @(posedge clk) begin
        if (!rst_n)      armed_q <= 1'b0;
        else if (tgt_wr) armed_q <= 1'b1;
        else if (fire)   armed_q <= 1'b0;
        else if (arm_wr) armed_q <= armed_q & arm_keep;
    end

    // Raw interrupt: set by a firing, cleared by writing 1; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       raw_q <= 1'b0;
        else if (fire)    raw_q <= 1'b1;
        else if (raw_clr) raw_q <= 1'b0;
    end
endmodule

// File: rtl/at_irq.sv
// Module: interrupt enable and force registers with the masked output.
// Assumes raw bits arrive registered from the alarm units.
module at_irq #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_wr,
    input  logic         force_wr,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] raw,
    output logic [N-1:0] en_q,
    output logic [N-1:0] force_q,
    output logic [N-1:0] irq
);
    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= wdata;
    end

    // Force register.
    always_ff @(posedge clk) begin
        if (!rst_n)        force_q <= '0;
        else if (force_wr) force_q <= wdata;
    end

    assign irq = (raw | force_q) & en_q;
endmodule

// File: rtl/alarm_timer.sv
// Module: top of the 64-bit timer, with register decode, lock and read mux.
// Assumes N_ALARMS <= 4 so that the targets fit in the 4-bit word address map.
module alarm_timer
    import alarm_timer_pkg::*;
#(
    parameter int unsigned N_ALARMS = 4,
    parameter int unsigned DW       = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [REG_AW-1:0]   addr,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       rdata,
    output logic [N_ALARMS-1:0] irq
);
    localparam int unsigned PADW = DW - N_ALARMS;

    logic [2*DW-1:0]      time_q;
    logic [DW-1:0]        stage_q;
    logic [DW-1:0]        hi_cap_q;
    logic                 lock_q;
    logic [N_ALARMS-1:0]  armed;
    logic [N_ALARMS-1:0]  raw;
    logic [N_ALARMS-1:0]  en_q;
    logic [N_ALARMS-1:0]  force_q;
    logic [DW-1:0]        tgt [N_ALARMS];
    logic [N_ALARMS*DW-1:0] tgt_flat;

    logic wr_time_ok;
    assign wr_time_ok = wr_en && !lock_q;

    // Sticky lock bit, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  lock_q <= 1'b0;
        else if (wr_en && addr == A_LOCK && wdata[0]) lock_q <= 1'b1;
    end

    at_timebase #(.HW(DW)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .stage_wr(wr_time_ok && addr == A_SET_LO),
        .commit_wr(wr_time_ok && addr == A_SET_HI),
        .cap_rd(rd_en && addr == A_RD_LO),
        .wdata(wdata), .time_q(time_q), .stage_q(stage_q), .hi_cap_q(hi_cap_q)
    );

    for (genvar i = 0; i < N_ALARMS; i++) begin : g_alarm
        at_alarm #(.HW(DW)) u_alm (
            .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
            .time_lo(time_q[DW-1:0]),
            .tgt_wr(wr_en && addr == A_TGT0 + REG_AW'(i)),
            .wdata(wdata),
            .arm_wr(wr_en && addr == A_ARMED),
            .arm_keep(wdata[i]),
            .raw_clr(wr_en && addr == A_RAW && wdata[i]),
            .armed_q(armed[i]), .raw_q(raw[i]), .tgt_q(tgt[i])
        );
        assign tgt_flat[i*DW +: DW] = tgt[i];
    end

    at_irq #(.N(N_ALARMS)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .en_wr(wr_en && addr == A_EN), .force_wr(wr_en && addr == A_FORCE),
        .wdata(wdata[N_ALARMS-1:0]), .raw(raw),
        .en_q(en_q), .force_q(force_q), .irq(irq)
    );

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            A_RD_LO, A_NOW_LO: rdata = time_q[DW-1:0];
            A_RD_HI:           rdata = hi_cap_q;
            A_NOW_HI:          rdata = time_q[2*DW-1:DW];
            A_LOCK:            rdata = {{(DW-1){1'b0}}, lock_q};
            A_ARMED:           rdata = {{PADW{1'b0}}, armed};
            A_RAW:             rdata = {{PADW{1'b0}}, raw};
            A_EN:              rdata = {{PADW{1'b0}}, en_q};
            A_FORCE:           rdata = {{PADW{1'b0}}, force_q};
            A_STAT:            rdata = {{PADW{1'b0}}, irq};
            default: begin
                for (int k = 0; k < N_ALARMS; k++)
                    if (addr == A_TGT0 + REG_AW'(k)) rdata = tgt[k];
            end
        endcase
    end
endmodule

// File: rtl/alarm_timer_chk.sv
// Module: property checker bound into alarm_timer; observes only, drives nothing.
module alarm_timer_chk
    import alarm_timer_pkg::*;
#(
    parameter int unsigned N  = 4,
    parameter int unsigned DW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wr_en,
    input logic [REG_AW-1:0] addr,
    input logic [DW-1:0]     wdata,
    input logic [2*DW-1:0]   time_q,
    input logic [DW-1:0]     stage_q,
    input logic              lock_q,
    input logic [N-1:0]      armed,
    input logic [N-1:0]      raw,
    input logic [N*DW-1:0]   tgt_flat
);
    logic commit;
    assign commit = wr_en && addr == A_SET_HI;

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !commit) |=> time_q == $past(time_q) + 1'b1);

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !commit) |=> $stable(time_q));

    assert_commit_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !lock_q) |=> time_q == {$past(wdata), $past(stage_q)});

    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    assert_lock_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && commit && !tick_en) |=> $stable(time_q));

    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_fire_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (armed[i] && tick_en && time_q[DW-1:0] == tgt_flat[i*DW +: DW]
             && !(wr_en && addr == A_TGT0 + REG_AW'(i)))
            |=> (!armed[i] && raw[i]));

        assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == A_RAW && wdata[i] && !(armed[i] && tick_en))
            |=> !raw[i]);
    end
endmodule

bind alarm_timer alarm_timer_chk #(.N(N_ALARMS), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .time_q(time_q), .stage_q(stage_q), .lock_q(lock_q),
    .armed(armed), .raw(raw), .tgt_flat(tgt_flat)
);

// File: tb/sim_alarm_timer.sv
// Bench: per-cycle reference model driven by bench functions, random plus directed stimulus.
module sim_alarm_timer;
    import alarm_timer_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq;

    int checks = 0;
    int errors = 0;

    // Reference state.
    logic [63:0] m_time;
    logic [31:0] m_stage, m_hicap;
    logic        m_lock;
    logic [3:0]  m_armed, m_raw, m_en, m_force;
    logic [31:0] m_tgt [4];

    always #2.5 clk = ~clk;

    alarm_timer u0 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

    function automatic logic [3:0] m_irq();
        return (m_raw | m_force) & m_en;
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            A_RD_LO, A_NOW_LO: return m_time[31:0];
            A_RD_HI:  return m_hicap;
            A_NOW_HI: return m_time[63:32];
            A_LOCK:   return {31'd0, m_lock};
            A_ARMED:  return {28'd0, m_armed};
            A_RAW:    return {28'd0, m_raw};
            A_EN:     return {28'd0, m_en};
            A_FORCE:  return {28'd0, m_force};
            A_STAT:   return {28'd0, m_irq()};
            4'd12, 4'd13, 4'd14, 4'd15: return m_tgt[a - 4'd12];
            default:  return 32'd0;
        endcase
    endfunction

    task automatic model_reset();
        m_time = '0; m_stage = '0; m_hicap = '0; m_lock = 1'b0;
        m_armed = '0; m_raw = '0; m_en = '0; m_force = '0;
        for (int i = 0; i < 4; i++) m_tgt[i] = '0;
    endtask

    // Advance the reference by one edge, from the inputs of that cycle.
    task automatic model_step(input logic w, input logic [3:0] a,
                              input logic [31:0] d, input logic r, input logic t);
        logic [3:0] fire;
        for (int i = 0; i < 4; i++)
            fire[i] = m_armed[i] && t && (m_time[31:0] == m_tgt[i]);
        if (r && a == A_RD_LO) m_hicap = m_time[63:32];
        if (w && a == A_SET_HI && !m_lock) m_time = {d, m_stage};
        else if (t) m_time = m_time + 64'd1;
        if (w && a == A_SET_LO && !m_lock) m_stage = d;
        for (int i = 0; i < 4; i++) begin
            if (w && a == 4'd12 + 4'(i)) begin m_armed[i] = 1'b1; m_tgt[i] = d; end
            else if (fire[i]) m_armed[i] = 1'b0;
            else if (w && a == A_ARMED) m_armed[i] = m_armed[i] & d[i];
            if (fire[i]) m_raw[i] = 1'b1;
            else if (w && a == A_RAW && d[i]) m_raw[i] = 1'b0;
        end
        if (w && a == A_EN)    m_en = d[3:0];
        if (w && a == A_FORCE) m_force = d[3:0];
        if (w && a == A_LOCK && d[0]) m_lock = 1'b1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, check mid-cycle, then step model at the edge.
    task automatic cyc(input logic w, input logic [3:0] a, input logic [31:0] d,
                       input logic r, input logic t, input string req);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; rd_en = r; tick_en = t;
        #1;
        check("R9 irq", {28'd0, irq}, {28'd0, m_irq()});
        if (r) check(req, rdata, m_read(a));
        @(posedge clk);
        model_step(w, a, d, r, t);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic t);
        cyc(1'b1, a, d, 1'b0, t, "");
    endtask

    task automatic rd(input logic [3:0] a, input logic t, input string req);
        cyc(1'b0, a, 32'd0, 1'b1, t, req);
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state of every readable register.
        for (int a = 2; a < 16; a++) rd(4'(a), 1'b0, "R1 reset");

        // R2: counting with tick_en, holding without it.
        for (int k = 0; k < 5; k++) wr(A_EN, 32'd0, 1'b1);
        rd(A_NOW_LO, 1'b0, "R2 count");
        rd(A_NOW_LO, 1'b0, "R2 hold");

        // R3: staging does not change time; commit overrides a tick; carry across halves (R2).
        wr(A_SET_LO, 32'hFFFF_FFFE, 1'b1);
        rd(A_NOW_LO, 1'b0, "R3 stage only");
        wr(A_SET_HI, 32'h0000_0001, 1'b1);
        rd(A_NOW_HI, 1'b0, "R3 commit hi");
        rd(A_NOW_LO, 1'b1, "R3 commit lo");
        rd(A_NOW_LO, 1'b1, "R2 carry lo");
        rd(A_NOW_HI, 1'b0, "R2 carry hi");

        // R4: capture high on low read, then stays while time moves.
        wr(A_SET_LO, 32'hFFFF_FFFF, 1'b0);
        wr(A_SET_HI, 32'h0000_00AA, 1'b0);
        rd(A_RD_LO, 1'b1, "R4 low read");
        for (int k = 0; k < 3; k++) wr(A_EN, 32'd0, 1'b1);
        rd(A_RD_HI, 1'b1, "R4 captured hi");
        rd(A_NOW_HI, 1'b0, "R4 live hi differs");

        // R5/R6: arm alarm 2 a few ticks ahead, watch it fire once.
        wr(A_EN, 32'hF, 1'b0);
        wr(4'd14, m_time[31:0] + 32'd3, 1'b0);
        rd(A_ARMED, 1'b0, "R5 armed");
        rd(4'd14, 1'b0, "R5 target readback");
        for (int k = 0; k < 5; k++) rd(A_RAW, 1'b1, "R6 fire");
        rd(A_ARMED, 1'b0, "R6 disarmed");

        // R8: write 0 no effect, write 1 clears.
        wr(A_RAW, 32'h0, 1'b0);
        rd(A_RAW, 1'b0, "R8 w0 keeps");
        wr(A_RAW, 32'h4, 1'b0);
        rd(A_RAW, 1'b0, "R8 w1 clears");

        // R8: firing beats clear on the same edge.
        wr(4'd12, m_time[31:0] + 32'd1, 1'b1);
        wr(A_RAW, 32'h1, 1'b1);
        rd(A_RAW, 1'b0, "R8 set wins");

        // R7: cancel with 0, writing 1 keeps.
        wr(4'd13, m_time[31:0] + 32'd4, 1'b0);
        wr(4'd15, m_time[31:0] + 32'd4, 1'b0);
        wr(A_ARMED, 32'h8, 1'b0);
        rd(A_ARMED, 1'b0, "R7 cancel");
        for (int k = 0; k < 6; k++) rd(A_RAW, 1'b1, "R7 cancelled silent");

        // R9: force and mask, status register.
        wr(A_RAW, 32'hF, 1'b0);
        wr(A_FORCE, 32'h5, 1'b0);
        rd(A_STAT, 1'b0, "R9 forced");
        wr(A_EN, 32'h4, 1'b0);
        rd(A_STAT, 1'b0, "R9 masked");
        wr(A_FORCE, 32'h0, 1'b0);
        wr(A_EN, 32'hF, 1'b0);

        // Random phase: mixed accesses, alarm targets near the current time.
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] a;
            logic t;
            int op;
            t = ($urandom % 4) != 0;
            op = $urandom % 10;
            if (op < 3) begin
                a = 4'd12 + 4'($urandom % 4);
                wr(a, m_time[31:0] + ($urandom % 24), t);
            end else if (op == 3) wr(A_ARMED, $urandom, t);
            else if (op == 4) wr(A_RAW, $urandom, t);
            else if (op == 5) wr(($urandom % 2) ? A_EN : A_FORCE, $urandom, t);
            else if (op == 6) wr(($urandom % 2) ? A_SET_LO : A_SET_HI, $urandom, t);
            else begin
                a = 4'($urandom % 16);
                if (a == A_LOCK || a < 4'd2) a = A_RD_LO;
                rd(a, t, "R4 R5 R6 random read");
            end
        end

        // R10: lock is sticky and blocks time writes.
        wr(A_LOCK, 32'h1, 1'b0);
        wr(A_LOCK, 32'h0, 1'b0);
        rd(A_LOCK, 1'b0, "R10 sticky");
        wr(A_SET_LO, 32'h1234_5678, 1'b0);
        wr(A_SET_HI, 32'h9ABC_DEF0, 1'b0);
        rd(A_NOW_LO, 1'b0, "R10 blocked lo");
        rd(A_NOW_HI, 1'b0, "R10 blocked hi");

        finish_run();
    end
endmodule